// File: doc/BRIEF.md
# Rotating Priority Resolver with Nesting

This block chooses which pending interrupt request goes to the processor. It gets the pending vector, the mask register and the in-service vector, and it searches them in a circular order. The search starts at the position given by a rotation base. A request is presented only if it outranks every line that is already in service. Two mode flags change how the in-service vector is counted:

- In special-mask mode, in-service lines that are masked are dropped from the comparison.
- In special-fully-nested mode, on the primary controller, the cascade line is dropped from it.

The block also reports the highest-priority line currently in service. End-of-interrupt handling uses this to know which bit to clear.

The whole selection is combinational. It settles within one clock, so the processor interrupt line is a single register fed by the result. Storage of the registers, command decoding and cascading of controllers are left to the surrounding logic. All control inputs are plain level signals, and there is no stream handshake.

Top module: `rot_prio_resolver`

## Requirements
- R1: With the rotation base at 0, the priority is fixed: line 0 is the highest and line 7 the lowest. The lowest-numbered candidate wins.
- R2: The search starts at the line named by the base and moves upward modulo 8. For example, with base 5 the order is 5, 6, 7, 0, 1, 2, 3, 4.
- R3: A line whose mask bit is 1 is never a candidate. The candidate set is `pend_i & ~mask_i`.
- R4: A candidate is presented only if its priority is strictly higher than the highest-priority counted in-service line. A pending line that is itself in service is therefore blocked.
- R5: When `spec_mask_i` is 1, in-service lines whose mask bit is 1 are left out of the in-service priority.
- R6: When `nested_i` and `is_primary_i` are both 1, in-service line 2 (the cascade input) is left out of the in-service priority. On a secondary controller (`is_primary_i` = 0), line 2 still counts.
- R7: With no candidate that qualifies, `req_valid_o` is 0 and `req_idx_o` is 0.
- R8: `eoi_valid_o`/`eoi_idx_o` give the highest-priority set bit of the raw in-service vector, searched from the base. Both are 0 when no line is in service.
- R9: `irq_line_o` is `req_valid_o` registered on the rising clock edge. It is 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the interrupt line register |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | 8 | Pending request vector |
| mask_i | input | 8 | Mask register, 1 = masked |
| insvc_i | input | 8 | In-service vector |
| base_i | input | 3 | Rotation base: the line searched first |
| spec_mask_i | input | 1 | Special-mask mode |
| nested_i | input | 1 | Special-fully-nested mode |
| is_primary_i | input | 1 | This controller is the primary one |
| req_valid_o | output | 1 | A request qualifies (combinational) |
| req_idx_o | output | 3 | Line number of the winning request |
| eoi_valid_o | output | 1 | At least one line is in service |
| eoi_idx_o | output | 3 | Highest-priority in-service line |
| irq_line_o | output | 1 | Registered processor interrupt line |

## Verification
The assertions assume the following about the inputs:
- All inputs are known, two-valued levels.
- The inputs change only away from the rising edge, so the combinational result sampled at an edge belongs to one input set.

Under these assumptions, the winner is always an unmasked pending line, and it is never a counted in-service line.

The stimulus drives every input set just after a falling edge and holds it across the next rising edge. The combinational outputs are read one nanosecond after the inputs are driven. `irq_line_o` is read after the following rising edge.

// File: rtl/rot_prio_pkg.sv
package rot_prio_pkg;
  localparam int unsigned PRIO_LINES   = 8;
  localparam int unsigned PRIO_CASCADE = 2;
endpackage

// File: rtl/rot_prio_scan.sv
module rot_prio_scan #(
  parameter int unsigned N  = rot_prio_pkg::PRIO_LINES,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [IW-1:0] base_i,
  output logic          found_o,
  output logic [IW:0]   rank_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] rot;

  for (genvar g = 0; g < N; g++) begin : g_rot
    logic [IW-1:0] pos;
    assign pos    = base_i + IW'(g);
    assign rot[g] = vec_i[pos];
  end

  always_comb begin
    rank_o = (IW+1)'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) rank_o = (IW+1)'(k);
    end
  end

  assign found_o = |rot;
  assign idx_o   = found_o ? (rank_o[IW-1:0] + base_i) : '0;
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver #(
  parameter int unsigned N       = rot_prio_pkg::PRIO_LINES,
  parameter int unsigned CASCADE = rot_prio_pkg::PRIO_CASCADE,
  localparam int unsigned IW     = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  insvc_i,
  input  logic [IW-1:0] base_i,
  input  logic          spec_mask_i,
  input  logic          nested_i,
  input  logic          is_primary_i,
  output logic          req_valid_o,
  output logic [IW-1:0] req_idx_o,
  output logic          eoi_valid_o,
  output logic [IW-1:0] eoi_idx_o,
  output logic          irq_line_o
);
  logic [N-1:0]  cand_vec;
  logic [N-1:0]  svc_vec;
  logic          cand_found;
  logic          svc_found;
  logic [IW:0]   cand_rank;
  logic [IW:0]   svc_rank;
  logic [IW:0]   eoi_rank;
  logic [IW-1:0] cand_idx;
  logic [IW-1:0] svc_idx;
  logic          req_win;

  assign cand_vec = pend_i & ~mask_i;

  always_comb begin
    svc_vec = insvc_i;
    if (spec_mask_i) svc_vec = svc_vec & ~mask_i;
    if (nested_i && is_primary_i) svc_vec[CASCADE] = 1'b0;
  end

  rot_prio_scan #(.N(N)) u_cand (
    .vec_i(cand_vec), .base_i(base_i),
    .found_o(cand_found), .rank_o(cand_rank), .idx_o(cand_idx)
  );

  rot_prio_scan #(.N(N)) u_svc (
    .vec_i(svc_vec), .base_i(base_i),
    .found_o(svc_found), .rank_o(svc_rank), .idx_o(svc_idx)
  );

  rot_prio_scan #(.N(N)) u_eoi (
    .vec_i(insvc_i), .base_i(base_i),
    .found_o(eoi_valid_o), .rank_o(eoi_rank), .idx_o(eoi_idx_o)
  );

  assign req_win     = cand_found && (!svc_found || (cand_rank < svc_rank));
  assign req_valid_o = req_win;
  assign req_idx_o   = req_win ? cand_idx : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_line_o <= 1'b0;
    else        irq_line_o <= req_win;
  end
endmodule

// File: rtl/rot_prio_resolver_chk.sv
module rot_prio_resolver_chk #(
  parameter int unsigned N       = rot_prio_pkg::PRIO_LINES,
  parameter int unsigned CASCADE = rot_prio_pkg::PRIO_CASCADE,
  localparam int unsigned IW     = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  pend_i,
  input logic [N-1:0]  mask_i,
  input logic [N-1:0]  insvc_i,
  input logic [IW-1:0] base_i,
  input logic          spec_mask_i,
  input logic          nested_i,
  input logic          is_primary_i,
  input logic          req_valid_o,
  input logic [IW-1:0] req_idx_o,
  input logic          eoi_valid_o,
  input logic [IW-1:0] eoi_idx_o,
  input logic          irq_line_o
);
  logic [N-1:0] below_win;
  assign below_win = (N'(1) << req_idx_o) - N'(1);

  AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (pend_i[req_idx_o] && !mask_i[req_idx_o])); // R3
  AST_FIXED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && base_i == '0) |-> ((pend_i & ~mask_i & below_win) == '0)); // R1
  AST_WIN_NOT_SERVICED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !(nested_i && is_primary_i && req_idx_o == IW'(CASCADE)))
      |-> !insvc_i[req_idx_o]); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_i & ~mask_i) == '0) |-> (!req_valid_o && req_idx_o == '0)); // R7
  AST_EOI_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid_o |-> insvc_i[eoi_idx_o]); // R8
  AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (insvc_i == '0) |-> !eoi_valid_o); // R8
  AST_LINE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |=> irq_line_o); // R9
  AST_LINE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_o |=> !irq_line_o); // R9
endmodule

bind rot_prio_resolver rot_prio_resolver_chk #(.N(N), .CASCADE(CASCADE)) u_chk (.*);

// File: tb/rot_prio_resolver_test.sv
module rot_prio_resolver_test;
  typedef struct packed {
    logic [7:0] pend;
    logic [7:0] mask;
    logic [7:0] isr;
    logic [2:0] base;
    logic       sm;
    logic       fn;
    logic       prim;
    logic       ev;
    logic [2:0] ei;
    logic       qv;
    logic [2:0] qi;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{8'h50, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 1'b0, 3'd0, 4'd1}, // R1
    '{8'h81, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 3'd0, 4'd1}, // R1
    '{8'h81, 8'h00, 8'h00, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd7, 1'b0, 3'd0, 4'd2}, // R2
    '{8'h06, 8'h00, 8'h00, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 3'd0, 4'd2}, // R2
    '{8'h05, 8'h01, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0, 3'd0, 4'd3}, // R3
    '{8'h05, 8'h05, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 4'd3}, // R3
    '{8'h10, 8'h00, 8'h04, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2, 4'd4}, // R4
    '{8'h02, 8'h00, 8'h04, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 3'd2, 4'd4}, // R4
    '{8'h04, 8'h00, 8'h04, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2, 4'd4}, // R4
    '{8'h10, 8'h04, 8'h04, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd4, 1'b1, 3'd2, 4'd5}, // R5
    '{8'h10, 8'h04, 8'h04, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2, 4'd5}, // R5
    '{8'h08, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd3, 1'b1, 3'd2, 4'd6}, // R6
    '{8'h08, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2, 4'd6}, // R6
    '{8'h04, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd2, 1'b1, 3'd2, 4'd6}, // R6
    '{8'h00, 8'h00, 8'h81, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd7, 4'd8}, // R8
    '{8'h09, 8'h00, 8'h10, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 1'b1, 3'd4, 4'd4}, // R4
    '{8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 4'd7}  // R7
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pend_i = '0, mask_i = '0, insvc_i = '0;
  logic [2:0] base_i = '0;
  logic       spec_mask_i = 1'b0, nested_i = 1'b0, is_primary_i = 1'b0;
  logic       req_valid_o, eoi_valid_o, irq_line_o;
  logic [2:0] req_idx_o, eoi_idx_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rot_prio_resolver uut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    pend_i = v.pend; mask_i = v.mask; insvc_i = v.isr; base_i = v.base;
    spec_mask_i = v.sm; nested_i = v.fn; is_primary_i = v.prim;
    #1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    pend_i = 8'h01;
    repeat (3) @(posedge clk);
    #1 check("R9 reset", irq_line_o, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      drive(TBL[i]);
      tag = $sformatf("R%0d vec%0d", TBL[i].req, i);
      check({tag, " valid"}, req_valid_o, TBL[i].ev);
      check({tag, " idx"}, req_idx_o, TBL[i].ei);
      check({tag, " eoi_valid R8"}, eoi_valid_o, TBL[i].qv);
      check({tag, " eoi_idx R8"}, eoi_idx_o, TBL[i].qi);
    end

    // R9: line follows valid one edge later
    drive('{8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 4'd9});
    @(posedge clk); #1 check("R9 low", irq_line_o, 0);
    drive('{8'h20, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 4'd9});
    check("R9 before edge", irq_line_o, 0);
    @(posedge clk); #1 check("R9 after edge", irq_line_o, 1);
    // R2 wrap at base 7: order 7,0,1..
    drive('{8'h41, 8'h00, 8'h00, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 4'd2});
    check("R2 wrap", req_idx_o, 0);
    // R5: special mask with unmasked in-service line still blocks
    drive('{8'h10, 8'h00, 8'h04, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 4'd5});
    check("R5 unmasked isr blocks", req_valid_o, 0);
    // R9: asynchronous reset clears line
    @(negedge clk) rst_n = 1'b0;
    #1 check("R9 async reset", irq_line_o, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule